// File: doc/BRIEF.md
# Timer-Matched Event Scheduler

This block produces timed level changes on ten output pins. Software hands it entries through a simple write port; each entry carries a 16-bit event time, a 4-bit channel number and a set/clear bit. Entries go into a pool of eight slots. The block does not compare every slot in parallel. A single comparator walks the occupied slots one clock at a time and checks each one against a free-running 16-bit timer, which it shares with the input-capture logic.

A walk over all slots starts whenever the timer value changes. When a slot's stored time equals the timer, the slot's command drives its output pin high or low. The slot then returns to the free pool, and a one-cycle done pulse is raised. Software watches the `full` flag and the free-slot count to know whether another entry can be accepted. A write made while the pool is full is dropped.

The walk needs eight clocks. The timer must therefore hold each value for at least eight clocks, so that no due event is skipped.

Top module: `evsched_top`

## Requirements
- R1: After reset all of `out_pins` are 0, `ev_done` is 0, `full` is 0 and `free_cnt` is 8.
- R2: When `wr_en` is high and a slot is free, the entry is stored in the lowest-numbered free slot, and `free_cnt` is one lower after the next clock edge.
- R3: When `wr_en` is high and all 8 slots are occupied (`full` = 1, `free_cnt` = 0), the write is dropped. The dropped entry never executes.
- R4: An executing entry with channel c in 0..9 drives `out_pins[c]` to its set bit (1 = high, 0 = low). No other pin changes.
- R5: An entry whose stored time differs from the timer value during a walk does not execute and keeps its slot.
- R6: An executed slot returns to the free pool, and `free_cnt` rises by one.
- R7: An entry with channel 10..15 still executes and frees its slot, and it pulses `ev_done`. It changes no output.
- R8: Entries that match in the same timer tick execute in ascending slot order, one per clock. When two of them target the same channel, the higher slot's command is the final value.
- R9: `ev_done` is high for exactly one clock per executed entry. It is high in the same cycle in which that entry's output change first appears.
- R10: A change of `timer_val` starts one walk. Slot k is examined on the (k+1)-th rising edge after the change, so its `ev_done` pulse appears k+1 clocks after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| timer_val | input | 16 | Shared free-running timer value |
| wr_en | input | 1 | Write an entry this cycle |
| wr_time | input | 16 | Event time of the written entry |
| wr_chan | input | 4 | Target channel of the written entry (0..9 are valid) |
| wr_set | input | 1 | 1 drives the pin high, 0 drives it low |
| out_pins | output | 10 | Output channel levels |
| ev_done | output | 1 | One-cycle pulse for each executed entry |
| full | output | 1 | No free slot is left |
| free_cnt | output | 4 | Number of free slots |

## Verification
The embedded properties check three behaviours on every clock:
- An accepted write occupies the chosen slot, an executed slot is freed, and a write made while full leaves the occupancy untouched.
- Outputs only move in a cycle that follows a match, and never for channels 10..15.
- `ev_done` tracks matches exactly, and a walk never wraps back to slot 0 within a tick.

Some behaviours need the bench's scenarios. These are the lowest-free-slot choice, the ascending execution order with the last-writer-wins result on one channel, the exact latency of a slot's event after a timer change, and a dropped entry that never fires after the pool drains.

// File: rtl/evsched_pkg.sv
// Shared widths and the stored entry format for the event scheduler.
package evsched_pkg;
    localparam int TIME_W = 16;
    localparam int CH_W   = 4;

    // One scheduled event: when it fires, which channel, and the level to drive.
    typedef struct packed {
        logic [TIME_W-1:0] t;
        logic [CH_W-1:0]   ch;
        logic              set;
    } ev_entry_t;
endpackage

// File: rtl/evsched_slots.sv
// Slot pool: holds entries with valid bits and takes writes into the lowest
// free slot. It exposes one read port for the scanner and frees one slot per
// clock on request.
// Assumes: the slot being freed is always a valid one, so a write and a free
// in the same cycle never touch the same slot.
module evsched_slots
    import evsched_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  ev_entry_t        wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output ev_entry_t        rd_entry,
    output logic             rd_valid,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic             full,
    output logic [CNT_W-1:0] free_cnt
);
    logic [NUM_SLOTS-1:0] valid_q;
    ev_entry_t            entry_q [NUM_SLOTS];
    logic [IDX_W-1:0]     alloc_idx;
    logic                 alloc_ok;
    logic                 wr_take;

    // Find the lowest-numbered free slot.
    always_comb begin
        alloc_idx = '0;
        alloc_ok  = 1'b0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                alloc_idx = IDX_W'(i);
                alloc_ok  = 1'b1;
            end
        end
    end

    // Count the free slots for status.
    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            free_cnt = free_cnt + CNT_W'(!valid_q[i]);
        end
    end

    assign full     = !alloc_ok;
    assign wr_take  = wr_en && alloc_ok;
    assign rd_entry = entry_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    // Occupy the slot on an accepted write; release the slot on execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) entry_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (wr_take && alloc_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    entry_q[i] <= wr_entry;
                end else if (clr_en && clr_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    AST_WRITE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> valid_q[$past(alloc_idx)]);            // R2
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !clr_en) |=> $stable(valid_q));           // R3
    AST_EXEC_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !valid_q[$past(clr_idx)]);                       // R6
endmodule

// File: rtl/evsched_scan.sv
// Sequential scanner: one comparator walks slot 0 to the last slot, one slot
// per clock. The walk starts in the first clock in which the timer value
// differs from the previous clock's value. It reports a hit when an occupied
// slot's time equals the timer.
// Assumes: the timer holds each value for at least NUM_SLOTS clocks.
module evsched_scan
    import evsched_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] timer_val,
    input  ev_entry_t         rd_entry,
    input  logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              hit
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

    logic [TIME_W-1:0] prev_q;
    logic [IDX_W-1:0]  ptr_q;
    logic              active_q;
    logic              tick;
    logic              look;

    assign tick   = (timer_val != prev_q);
    assign rd_idx = tick ? '0 : ptr_q;
    assign look   = tick || active_q;
    assign hit    = look && rd_valid && (rd_entry.t == timer_val);

    // Track the timer and step the walk pointer through one pass per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            ptr_q    <= '0;
            active_q <= 1'b0;
        end else begin
            prev_q <= timer_val;
            if (look) begin
                ptr_q    <= rd_idx + 1'b1;
                active_q <= (rd_idx != LAST);
            end
        end
    end

    AST_NO_WRAP_IN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !tick) |-> (rd_idx != '0));                    // R10
    AST_WALK_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (look && rd_idx != LAST) |=> active_q);                     // R10
endmodule

// File: rtl/evsched_exec.sv
// Command executor: on a hit, drives the addressed output to the entry's
// level and raises the done pulse. Channel numbers past the last output
// still count as executed but change no pin.
// Assumes: at most one hit per clock (one comparator).
module evsched_exec
    import evsched_pkg::*;
#(
    parameter int NUM_OUTS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  ev_entry_t           entry,
    output logic [NUM_OUTS-1:0] out_pins,
    output logic                done
);
    logic [NUM_OUTS-1:0] out_q;
    logic                done_q;

    // Apply the matched command and register the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= hit;
            for (int o = 0; o < NUM_OUTS; o++) begin
                if (hit && int'(entry.ch) == o) out_q[o] <= entry.set;
            end
        end
    end

    assign out_pins = out_q;
    assign done     = done_q;

    AST_HOLD_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(out_q));                                   // R4
    AST_IGNORE_HIGH_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && int'(entry.ch) >= NUM_OUTS) |=> $stable(out_q));    // R7
    AST_DONE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> done_q);                                            // R9
    AST_DONE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !done_q);                                          // R9
endmodule

// File: rtl/evsched_top.sv
// Timer-matched event scheduler top. It ties together the slot pool, the
// single-comparator scanner and the command executor.
// Assumes: timer_val is free-running and holds each value for >= NUM_SLOTS clocks.
module evsched_top
    import evsched_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_OUTS  = 10,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TIME_W-1:0]   timer_val,
    input  logic                wr_en,
    input  logic [TIME_W-1:0]   wr_time,
    input  logic [CH_W-1:0]     wr_chan,
    input  logic                wr_set,
    output logic [NUM_OUTS-1:0] out_pins,
    output logic                ev_done,
    output logic                full,
    output logic [CNT_W-1:0]    free_cnt
);
    ev_entry_t        wr_entry;
    ev_entry_t        rd_entry;
    logic             rd_valid;
    logic [IDX_W-1:0] rd_idx;
    logic             hit;

    assign wr_entry = '{t: wr_time, ch: wr_chan, set: wr_set};

    evsched_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
        .rd_idx(rd_idx), .rd_entry(rd_entry), .rd_valid(rd_valid),
        .clr_en(hit), .clr_idx(rd_idx), .full(full), .free_cnt(free_cnt)
    );

    evsched_scan #(.NUM_SLOTS(NUM_SLOTS)) u_scan (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
        .rd_entry(rd_entry), .rd_valid(rd_valid), .rd_idx(rd_idx), .hit(hit)
    );

    evsched_exec #(.NUM_OUTS(NUM_OUTS)) u_exec (
        .clk(clk), .rst_n(rst_n), .hit(hit), .entry(rd_entry),
        .out_pins(out_pins), .done(ev_done)
    );
endmodule

// File: tb/tb_evsched_top.sv
// Scoreboard bench: the driver tasks model slot allocation and predict the
// pin image after each event. A monitor pops one prediction per ev_done pulse.
module tb_evsched_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_time = '0;
    logic [3:0]  wr_chan = '0;
    logic        wr_set = 1'b0;
    logic [9:0]  out_pins;
    logic        ev_done;
    logic        full;
    logic [3:0]  free_cnt;

    evsched_top dut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .wr_en(wr_en),
        .wr_time(wr_time), .wr_chan(wr_chan), .wr_set(wr_set),
        .out_pins(out_pins), .ev_done(ev_done), .full(full), .free_cnt(free_cnt)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [9:0] exp_q[$];
    int done_cycs[$];
    logic [9:0] m_pins = '0;
    logic       m_valid [8];
    logic [15:0] m_time [8];
    logic [3:0]  m_ch [8];
    logic        m_set [8];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: each done pulse must match the next predicted pin image.
    always @(negedge clk) begin
        if (rst_n && ev_done) begin
            done_cycs.push_back(cyc);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected ev_done", 1, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk(out_pins == e, "R4/R8/R9 pins at ev_done", int'(out_pins), int'(e));
            end
        end
    end

    function automatic int model_free();
        int n = 0;
        for (int s = 0; s < 8; s++) if (!m_valid[s]) n++;
        return n;
    endfunction

    // Driver: one write, with the model picking the lowest free slot.
    task automatic wr(input logic [15:0] t, input logic [3:0] ch, input logic st);
        @(negedge clk);
        wr_en = 1'b1; wr_time = t; wr_chan = ch; wr_set = st;
        @(negedge clk);
        wr_en = 1'b0;
        for (int s = 0; s < 8; s++) begin
            if (!m_valid[s]) begin
                m_valid[s] = 1'b1; m_time[s] = t; m_ch[s] = ch; m_set[s] = st;
                break;
            end
        end
        chk(free_cnt == 4'(model_free()), "R2/R3 free_cnt after write",
            int'(free_cnt), model_free());
    endtask

    // Driver: move the timer, predict events in slot order, let the walk finish.
    task automatic advance(input logic [15:0] v, output int start);
        for (int s = 0; s < 8; s++) begin
            if (m_valid[s] && m_time[s] == v) begin
                if (m_ch[s] < 4'd10) m_pins[m_ch[s]] = m_set[s];
                exp_q.push_back(m_pins);
                m_valid[s] = 1'b0;
            end
        end
        done_cycs.delete();
        @(negedge clk);
        timer_val = v;
        start = cyc;
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all predicted events seen", exp_q.size(), 0);
        chk(out_pins == m_pins, "R4/R5 pins after tick", int'(out_pins), int'(m_pins));
        chk(free_cnt == 4'(model_free()), "R5/R6 free_cnt after tick",
            int'(free_cnt), model_free());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int st;
        for (int s = 0; s < 8; s++) m_valid[s] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_pins == '0, "R1 out_pins", int'(out_pins), 0);
        chk(!ev_done, "R1 ev_done", int'(ev_done), 0);
        chk(!full, "R1 full", int'(full), 0);
        chk(free_cnt == 4'd8, "R1 free_cnt", int'(free_cnt), 8);

        // R4 R6 single event
        wr(16'd5, 4'd3, 1'b1);
        advance(16'd5, st);

        // R8 same channel, set then clear: clear wins; one per clock (R10)
        wr(16'd10, 4'd2, 1'b1);
        wr(16'd10, 4'd2, 1'b0);
        advance(16'd10, st);
        chk(done_cycs.size() == 2, "R8 two events", done_cycs.size(), 2);
        if (done_cycs.size() == 2) begin
            chk(done_cycs[0] - st == 1, "R10 slot0 latency", done_cycs[0] - st, 1);
            chk(done_cycs[1] - st == 2, "R8 consecutive clocks", done_cycs[1] - st, 2);
        end
        chk(out_pins[2] == 1'b0, "R8 higher slot final (clear)", int'(out_pins[2]), 0);

        // R8 reversed order: set wins
        wr(16'd12, 4'd2, 1'b0);
        wr(16'd12, 4'd2, 1'b1);
        advance(16'd12, st);
        chk(out_pins[2] == 1'b1, "R8 higher slot final (set)", int'(out_pins[2]), 1);

        // R7 channel 12 ignored but executed
        wr(16'd20, 4'd12, 1'b1);
        advance(16'd20, st);
        chk(done_cycs.size() == 1, "R7 ev_done for ignored channel", done_cycs.size(), 1);

        // R5 non-matching time stays pending, then fires
        wr(16'd200, 4'd6, 1'b1);
        advance(16'd150, st);
        chk(done_cycs.size() == 0, "R5 no event on mismatch", done_cycs.size(), 0);
        chk(out_pins[6] == 1'b0, "R5 pin6 untouched", int'(out_pins[6]), 0);
        advance(16'd200, st);
        chk(out_pins[6] == 1'b1, "R4 pin6 set", int'(out_pins[6]), 1);

        // R10 latency of slot 2 (R2 lowest free slot puts it there)
        wr(16'd900, 4'd0, 1'b1);
        wr(16'd900, 4'd1, 1'b1);
        wr(16'd300, 4'd5, 1'b1);
        advance(16'd300, st);
        chk(done_cycs.size() == 1, "R10 one event", done_cycs.size(), 1);
        if (done_cycs.size() == 1)
            chk(done_cycs[0] - st == 3, "R10 slot2 latency", done_cycs[0] - st, 3);

        // R3 fill the pool, drop an extra write, drain
        wr(16'd900, 4'd4, 1'b1);
        wr(16'd900, 4'd7, 1'b1);
        wr(16'd900, 4'd8, 1'b1);
        wr(16'd900, 4'd0, 1'b0);
        wr(16'd900, 4'd1, 1'b0);
        wr(16'd900, 4'd2, 1'b0);
        chk(full == 1'b1, "R3 full flag", int'(full), 1);
        wr(16'd900, 4'd9, 1'b1);
        chk(full == 1'b1 && free_cnt == 4'd0, "R3 rejected write", int'(free_cnt), 0);
        advance(16'd900, st);
        chk(done_cycs.size() == 8, "R3 only stored entries fire", done_cycs.size(), 8);
        chk(out_pins[9] == 1'b0, "R3 dropped entry never runs", int'(out_pins[9]), 0);
        chk(!full, "R6 pool drained", int'(full), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule